// File: doc/BRIEF.md
# Dual-Speed Single-Line Bus Master

This block runs bit-level transactions on one open-drain, single-wire serial bus. A host asks for one slot at a time by raising `cmd_valid` with an opcode: a reset/presence sequence, a write of one bit, or a read of one bit. The block pulls the line low through `line_oe` for the time that slot calls for, then releases it. At a fixed point in the slot it samples the line through a two-flop synchroniser. At the end it raises `done` for one cycle and leaves the outcome on `result`: the presence flag for a reset, or the sampled line level for a data slot.

Timing comes from the system clock, with `TICKS_PER_US` clock cycles per microsecond. Internally the block counts in half-microsecond units. The `overdrive` input chooses between the standard and the fast timing profile. Its value is taken only when a command is accepted, so it governs that whole slot. Every slot, recovery included, runs for a fixed length, and a new command can be accepted once `busy` has dropped.

Top module: `owire_master`

## Requirements
- R1: After reset, `line_oe`, `busy`, `done` and `result` are all 0.
- R2: A reset command (opcode 0) drives `line_oe` high for 500 µs at standard speed and 70 µs at overdrive, starting the cycle after acceptance.
- R3: For a reset, the line is sampled 70 µs (standard) or 9 µs (overdrive) after the release. `result` becomes 1 if the line is low there (device present) and 0 if it is high.
- R4: A reset sequence keeps `busy` high for 1000 µs (standard) or 140 µs (overdrive). `done` pulses for exactly one cycle as `busy` falls.
- R5: A write command (opcode 1) with `cmd_wbit`=0 drives `line_oe` high for 60 µs (standard) or 10 µs (overdrive).
- R6: A write command with `cmd_wbit`=1, or a read command (opcode 2), drives `line_oe` high for 6 µs (standard) or 1 µs (overdrive).
- R7: In a write or read slot, `result` takes the synchronised line level (1 = high) at 13 µs (standard) or 1.5 µs (overdrive) after the slot starts.
- R8: A write or read slot keeps `busy` high for 75 µs (standard) or 12 µs (overdrive). This is the 70 µs or 10 µs slot plus released-line recovery. `done` pulses once at the end.
- R9: `cmd_valid` while `busy` is high is ignored. Opcode 3 is never accepted.
- R10: A change of `overdrive` during a slot does not alter that slot's timing.
- R11: `line_sync` equals `line_in` delayed by two clock cycles, and `line_oe` changes only on clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command request, taken when busy is low |
| cmd_op | input | 2 | 0 reset/presence, 1 write bit, 2 read bit, 3 none |
| cmd_wbit | input | 1 | Bit value for a write command |
| overdrive | input | 1 | 1 selects overdrive timing for the next slot |
| line_in | input | 1 | Raw level of the bus line |
| busy | output | 1 | A slot is in progress |
| done | output | 1 | One-cycle pulse at the end of a slot |
| result | output | 1 | Presence flag or sampled bit of the last slot |
| line_oe | output | 1 | Registered enable of the low-side line driver |
| line_sync | output | 1 | Synchronised line level |

## Verification
The vector table runs every opcode, and each write value, at both speeds. A simulated device holds the line low for chosen lengths after the master releases it. For a reset, a long hold against no hold tells presence from absence. For a read, a hold that ends just before the sample point is set against one that ends just after it, which places the sample within a few clock cycles. Counting the cycles of driven low and of busy on each slot separates the write-0, write-1/read and reset low times and the two slot lengths. Directed runs change the speed input and inject commands mid-slot, issue the unused opcode, and step the raw line to check the two-cycle delay of the synchroniser.

// File: rtl/owm_pkg.sv
package owm_pkg;

    localparam int HALF_W = 12;

    typedef enum logic [1:0] {
        OP_RESET = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2,
        OP_NONE  = 2'd3
    } op_e;

    // all durations in half-microsecond units from slot start
    typedef struct packed {
        logic [HALF_W-1:0] low_end;
        logic [HALF_W-1:0] sample_at;
        logic [HALF_W-1:0] slot_end;
    } slot_tm_t;

    localparam int STD_RST_LOW   = 1000;
    localparam int STD_RST_SMP   = 1140;
    localparam int STD_RST_END   = 2000;
    localparam int STD_W0_LOW    = 120;
    localparam int STD_SHORT_LOW = 12;
    localparam int STD_BIT_SMP   = 26;
    localparam int STD_BIT_END   = 150;

    localparam int OD_RST_LOW    = 140;
    localparam int OD_RST_SMP    = 158;
    localparam int OD_RST_END    = 280;
    localparam int OD_W0_LOW     = 20;
    localparam int OD_SHORT_LOW  = 2;
    localparam int OD_BIT_SMP    = 3;
    localparam int OD_BIT_END    = 24;

    function automatic slot_tm_t pick_timing(input op_e op, input logic wbit,
                                             input logic fast);
        slot_tm_t t;
        if (op == OP_RESET) begin
            t.low_end   = HALF_W'(fast ? OD_RST_LOW : STD_RST_LOW);
            t.sample_at = HALF_W'(fast ? OD_RST_SMP : STD_RST_SMP);
            t.slot_end  = HALF_W'(fast ? OD_RST_END : STD_RST_END);
        end else begin
            if (op == OP_WRITE && !wbit)
                t.low_end = HALF_W'(fast ? OD_W0_LOW : STD_W0_LOW);
            else
                t.low_end = HALF_W'(fast ? OD_SHORT_LOW : STD_SHORT_LOW);
            t.sample_at = HALF_W'(fast ? OD_BIT_SMP : STD_BIT_SMP);
            t.slot_end  = HALF_W'(fast ? OD_BIT_END : STD_BIT_END);
        end
        return t;
    endfunction

endpackage

// File: rtl/owm_sync.sv
module owm_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= chain_d;
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/owm_prescale.sv
module owm_prescale #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (!run || cnt_q == LAST) cnt_d = '0;
        else                       cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick = run && (cnt_q == LAST);
endmodule

// File: rtl/owm_slot_ctrl.sv
module owm_slot_ctrl
    import owm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [1:0] cmd_op,
    input  logic       cmd_wbit,
    input  logic       overdrive,
    input  logic       tick,
    input  logic       line_lvl,
    output logic       busy,
    output logic       done,
    output logic       result,
    output logic       line_oe
);
    typedef struct packed {
        logic              busy;
        logic              done;
        logic              result;
        logic              oe;
        logic              is_rst;
        logic [HALF_W-1:0] elapsed;
        slot_tm_t          tm;
    } ctrl_t;

    ctrl_t st_d, st_q;
    logic [HALF_W-1:0] el_next;
    op_e op_in;

    always_comb begin
        op_in   = op_e'(cmd_op);
        st_d    = st_q;
        st_d.done = 1'b0;
        el_next = st_q.elapsed + 1'b1;
        if (!st_q.busy) begin
            if (cmd_valid && op_in != OP_NONE) begin
                st_d.busy    = 1'b1;
                st_d.oe      = 1'b1;
                st_d.is_rst  = (op_in == OP_RESET);
                st_d.elapsed = '0;
                st_d.tm      = pick_timing(op_in, cmd_wbit, overdrive);
            end
        end else if (tick) begin
            st_d.elapsed = el_next;
            if (el_next >= st_q.tm.low_end)
                st_d.oe = 1'b0;
            if (el_next == st_q.tm.sample_at)
                st_d.result = st_q.is_rst ? ~line_lvl : line_lvl;
            if (el_next == st_q.tm.slot_end) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
                st_d.oe   = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy    = st_q.busy;
    assign done    = st_q.done;
    assign result  = st_q.result;
    assign line_oe = st_q.oe;
endmodule

// File: rtl/owire_master.sv
module owire_master #(
    parameter int TICKS_PER_US = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [1:0] cmd_op,
    input  logic       cmd_wbit,
    input  logic       overdrive,
    input  logic       line_in,
    output logic       busy,
    output logic       done,
    output logic       result,
    output logic       line_oe,
    output logic       line_sync
);
    localparam int TICKS_PER_HALF = (TICKS_PER_US / 2 > 0) ? TICKS_PER_US / 2 : 1;

    logic tick;

    owm_sync #(.STAGES(2), .RST_VAL(1'b1)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (line_in),
        .q    (line_sync)
    );

    owm_prescale #(.DIV(TICKS_PER_HALF)) u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (busy),
        .tick (tick)
    );

    owm_slot_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_valid(cmd_valid),
        .cmd_op   (cmd_op),
        .cmd_wbit (cmd_wbit),
        .overdrive(overdrive),
        .tick     (tick),
        .line_lvl (line_sync),
        .busy     (busy),
        .done     (done),
        .result   (result),
        .line_oe  (line_oe)
    );
endmodule

// File: rtl/owm_checker.sv
module owm_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic [1:0] cmd_op,
    input logic       busy,
    input logic       done,
    input logic       result,
    input logic       line_oe,
    input logic       line_in,
    input logic       line_sync
);
    logic [1:0] warm_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          warm_q <= '0;
        else if (warm_q != 2'd3) warm_q <= warm_q + 1'b1;
    end

    AST_OE_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        line_oe |-> busy); // R2

    AST_DONE_AT_BUSY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy))); // R4

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8

    AST_START_NEEDS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(cmd_valid) && $past(cmd_op) != 2'd3)); // R9

    AST_OE_RISES_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(line_oe) |-> $rose(busy)); // R6

    AST_RESULT_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(busy) |-> $stable(result)); // R7

    AST_SYNC_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd3) |-> (line_sync == $past(line_in, 2))); // R11
endmodule

bind owire_master owm_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_valid(cmd_valid),
    .cmd_op   (cmd_op),
    .busy     (busy),
    .done     (done),
    .result   (result),
    .line_oe  (line_oe),
    .line_in  (line_in),
    .line_sync(line_sync)
);

// File: tb/sim_owire_master.sv
module sim_owire_master;
    localparam int CLK_PERIOD = 10;
    localparam int CPU = 8;            // clock cycles per microsecond
    localparam int WATCHDOG = 190000;
    localparam int NV = 12;

    // opcode, write bit, overdrive, device hold cycles, result, low cycles, busy cycles
    localparam int V_OP [NV] = '{0, 0, 0, 0, 1, 1, 1, 1, 2, 2, 2, 2};
    localparam int V_WB [NV] = '{0, 0, 0, 0, 0, 1, 0, 1, 0, 0, 0, 0};
    localparam int V_OD [NV] = '{0, 0, 1, 1, 0, 0, 1, 1, 0, 0, 1, 1};
    localparam int V_DEV[NV] = '{100*CPU, 0, 10*CPU, 0, 0, 0, 0, 0, 40, 70, 1, 4};
    localparam int V_RES[NV] = '{1, 0, 1, 0, 0, 1, 0, 1, 1, 0, 1, 0};
    localparam int V_LOW[NV] = '{500*CPU, 500*CPU, 70*CPU, 70*CPU, 60*CPU, 6*CPU,
                                 10*CPU, 1*CPU, 6*CPU, 6*CPU, 1*CPU, 1*CPU};
    localparam int V_TOT[NV] = '{1000*CPU, 1000*CPU, 140*CPU, 140*CPU, 75*CPU, 75*CPU,
                                 12*CPU, 12*CPU, 75*CPU, 75*CPU, 12*CPU, 12*CPU};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'd0;
    logic cmd_wbit = 1'b0;
    logic overdrive = 1'b0;
    logic line_in;
    logic busy, done, result, line_oe, line_sync;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int dev_len = 0;
    int dev_cnt = 0;
    logic ext_low = 1'b0;
    logic prev_oe = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign line_in = ~(line_oe | (dev_cnt > 0) | ext_low);

    // device model: holds the line low for dev_len cycles after master release
    always @(negedge clk) begin
        if (prev_oe && !line_oe && dev_len > 0) dev_cnt = dev_len;
        else if (dev_cnt > 0)                   dev_cnt = dev_cnt - 1;
        prev_oe = line_oe;
    end

    owire_master #(.TICKS_PER_US(CPU)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_wbit(cmd_wbit), .overdrive(overdrive), .line_in(line_in),
        .busy(busy), .done(done), .result(result), .line_oe(line_oe),
        .line_sync(line_sync)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG) begin
            check("watchdog", cyc, WATCHDOG);
            finish_run();
        end
    end

    // inj_at: cycle index within the slot for a disturbance (-1 none)
    task automatic run_slot(input int op, input int wb, input int od, input int dlen,
                            input int inj_at, input bit inj_cmd,
                            output int lowc, output int totc, output int res);
        int idx = 0;
        lowc = 0;
        totc = 0;
        @(negedge clk);
        dev_len   = dlen;
        cmd_op    = 2'(op);
        cmd_wbit  = wb[0];
        overdrive = od[0];
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        while (!done && idx < 20000) begin
            if (busy)    totc++;
            if (line_oe) lowc++;
            if (idx == inj_at) begin
                overdrive = ~overdrive;
                if (inj_cmd) begin
                    cmd_op    = 2'd0;
                    cmd_valid = 1'b1;
                end
            end else begin
                cmd_valid = 1'b0;
            end
            idx++;
            @(negedge clk);
        end
        res = int'(result);
        @(negedge clk);
        check("R4 R8 done single cycle", int'(done), 0);
        dev_len = 0;
    endtask

    initial begin
        int lc, tc, rs;
        repeat (3) @(negedge clk);
        check("R1 oe", int'(line_oe), 0);
        check("R1 busy", int'(busy), 0);
        check("R1 done", int'(done), 0);
        check("R1 result", int'(result), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R1 idle after release", int'(busy), 0);

        for (int i = 0; i < NV; i++) begin
            run_slot(V_OP[i], V_WB[i], V_OD[i], V_DEV[i], -1, 1'b0, lc, tc, rs);
            if (V_OP[i] == 0) begin
                check("R2 reset low time", lc, V_LOW[i]);
                check("R4 reset busy time", tc, V_TOT[i]);
                check("R3 presence", rs, V_RES[i]);
            end else begin
                if (V_OP[i] == 1 && V_WB[i] == 0)
                    check("R5 write-0 low time", lc, V_LOW[i]);
                else
                    check("R6 short low time", lc, V_LOW[i]);
                check("R8 slot busy time", tc, V_TOT[i]);
                check("R7 sampled level", rs, V_RES[i]);
            end
            repeat (3) @(negedge clk);
        end

        // R10: overdrive flips mid-slot, standard write-1 keeps standard timing
        run_slot(1, 1, 0, 0, 20, 1'b0, lc, tc, rs);
        check("R10 low time unchanged", lc, 6*CPU);
        check("R10 busy time unchanged", tc, 75*CPU);
        overdrive = 1'b0;

        // R9: reset command injected while busy has no effect
        run_slot(1, 1, 0, 0, 30, 1'b1, lc, tc, rs);
        check("R9 low time unchanged", lc, 6*CPU);
        check("R9 busy time unchanged", tc, 75*CPU);
        overdrive = 1'b0;
        repeat (6) @(negedge clk);
        check("R9 no slot after injected command", int'(busy), 0);

        // R9: opcode 3 never starts a slot
        cmd_op = 2'd3;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (3) @(negedge clk);
        check("R9 opcode 3 busy", int'(busy), 0);
        check("R9 opcode 3 oe", int'(line_oe), 0);

        // R11: two-cycle synchroniser delay
        check("R11 idle line", int'(line_sync), 1);
        ext_low = 1'b1;
        @(negedge clk);
        check("R11 after one edge", int'(line_sync), 1);
        @(negedge clk);
        check("R11 after two edges", int'(line_sync), 0);
        ext_low = 1'b0;
        repeat (2) @(negedge clk);
        check("R11 released line", int'(line_sync), 1);

        finish_run();
    end
endmodule